// File: doc/BRIEF.md
# Two-Button Serial Passcode Lock

This block is the control core of a simple keypad-less lock. A user keys in a binary code one digit at a time. One push button enters a `1` digit and a second push button enters a `0` digit. The block compares the sequence against a fixed passcode set by a parameter. The default passcode is four digits long and reads 1, 0, 1, 0 in entry order.

The lock does not react to a wrong digit as soon as it arrives. It keeps collecting digits, and only after the last one does it light either the pass lamp or the fail lamp. That lamp stays lit, and all further presses are ignored, until the reset input is asserted. Reset also discards any partial entry.

The button inputs are expected to arrive already synchronized to `clk` and free of bounce. Inside the block, each button goes through a rising-edge detector, so one press counts as one digit however long the button is held. Both lamps are plain level outputs, and they follow the internal state register directly.

Top module: `serial_code_lock`

## Requirements
- R1: While `rst` is high at a clock edge, both `pass_led` and `fail_led` go low after that edge, and the count of entered digits returns to zero.
- R2: A rising edge on `btn_one` enters the digit 1, and a rising edge on `btn_zero` enters the digit 0. The default passcode is 1, 0, 1, 0, with the first entered digit first.
- R3: Each press is exactly one digit. A button held high for many cycles adds no further digits.
- R4: If both buttons rise in the same cycle, that cycle enters no digit.
- R5: At the clock edge that samples the fourth digit, `pass_led` goes high if all four digits matched the passcode.
- R6: At the clock edge that samples the fourth digit, `fail_led` goes high if any of the four digits differed from the passcode.
- R7: Before the fourth digit, both lamps stay low, even if an earlier digit was already wrong.
- R8: Once a lamp is lit, it holds its value and every press is ignored until `rst`.
- R9: `pass_led` and `fail_led` are never high together.
- R10: A button that is held high across the release of `rst` is not counted as a press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_one | input | 1 | Button that enters a 1 digit (synchronized, debounced) |
| btn_zero | input | 1 | Button that enters a 0 digit (synchronized, debounced) |
| pass_led | output | 1 | High when a complete entry matched the passcode |
| fail_led | output | 1 | High when a complete entry did not match |

## Verification
The assertions assume that the button levels change only between clock edges and are already clean. Under that assumption, a rise seen by the property sampling is the same rise the edge detector sees. They also assume that `rst` is high from time zero, so the reset property starts from a known value. The bench meets both assumptions: it changes `btn_one`, `btn_zero` and `rst` only on falling clock edges, and it holds `rst` high from the first instant. Every press in the bench lasts at least one full cycle with the button released for a full cycle afterwards, except in the deliberate hold and simultaneous-press tests.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

  // Index of each button in the packed button vector.
  localparam int BTN_ONE_IDX  = 0;
  localparam int BTN_ZERO_IDX = 1;
  localparam int NUM_BTN      = 2;

  // Entry is collecting digits; the other two states are the held verdicts.
  typedef enum logic [1:0] {
    ST_ENTRY = 2'd0,
    ST_PASS  = 2'd1,
    ST_FAIL  = 2'd2
  } lock_state_e;

endpackage

// File: rtl/btn_rise_detect.sv
module btn_rise_detect #(
  parameter int N_BTN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] btn_i,
  output logic [N_BTN-1:0] rise_o
);

  logic [N_BTN-1:0] prev_q;

  // The previous level resets to all ones. A button that is held through
  // reset then reads as already high, so its release of reset is no press.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= btn_i;
  end

  for (genvar g = 0; g < N_BTN; g++) begin : g_rise
    assign rise_o[g] = btn_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/digit_select.sv
module digit_select
  import code_lock_pkg::*;
(
  input  logic [NUM_BTN-1:0] rise_i,
  output logic               dig_vld_o,
  output logic               dig_val_o
);

  // Exactly one rising button forms a digit; two at once cancel out.
  assign dig_vld_o = rise_i[BTN_ONE_IDX] ^ rise_i[BTN_ZERO_IDX];
  assign dig_val_o = rise_i[BTN_ONE_IDX];

endmodule

// File: rtl/code_seq_matcher.sv
module code_seq_matcher
  import code_lock_pkg::*;
#(
  parameter int                CODE_LEN = 4,
  parameter logic [CODE_LEN-1:0] PASSCODE = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic dig_vld_i,
  input  logic dig_val_i,
  output logic pass_o,
  output logic fail_o
);

  localparam int CNT_W = (CODE_LEN > 1) ? $clog2(CODE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CODE_LEN - 1);

  lock_state_e     state_q;
  logic [CNT_W-1:0] pos_q;
  logic            miss_q;
  logic [CODE_LEN-1:0] order;
  logic            exp_bit;
  logic            dig_bad;

  // The passcode's most significant bit is the first digit entered.
  for (genvar g = 0; g < CODE_LEN; g++) begin : g_order
    assign order[g] = PASSCODE[CODE_LEN-1-g];
  end

  assign exp_bit = order[pos_q];
  assign dig_bad = (dig_val_i != exp_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ENTRY;
      pos_q   <= '0;
      miss_q  <= 1'b0;
    end else if (state_q == ST_ENTRY && dig_vld_i) begin
      if (pos_q == LAST_POS) begin
        state_q <= (miss_q || dig_bad) ? ST_FAIL : ST_PASS;
        pos_q   <= '0;
        miss_q  <= 1'b0;
      end else begin
        pos_q  <= pos_q + 1'b1;
        miss_q <= miss_q | dig_bad;
      end
    end
  end

  assign pass_o = (state_q == ST_PASS);
  assign fail_o = (state_q == ST_FAIL);

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import code_lock_pkg::*;
#(
  parameter int                  CODE_LEN = 4,
  parameter logic [CODE_LEN-1:0] PASSCODE = 4'b1010
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_one,
  input  logic btn_zero,
  output logic pass_led,
  output logic fail_led
);

  logic [NUM_BTN-1:0] btn_vec;
  logic [NUM_BTN-1:0] btn_rise;
  logic               dig_vld;
  logic               dig_val;

  assign btn_vec[BTN_ONE_IDX]  = btn_one;
  assign btn_vec[BTN_ZERO_IDX] = btn_zero;

  btn_rise_detect #(.N_BTN(NUM_BTN)) u_rise (
    .clk    (clk),
    .rst    (rst),
    .btn_i  (btn_vec),
    .rise_o (btn_rise)
  );

  digit_select u_sel (
    .rise_i    (btn_rise),
    .dig_vld_o (dig_vld),
    .dig_val_o (dig_val)
  );

  code_seq_matcher #(.CODE_LEN(CODE_LEN), .PASSCODE(PASSCODE)) u_match (
    .clk       (clk),
    .rst       (rst),
    .dig_vld_i (dig_vld),
    .dig_val_i (dig_val),
    .pass_o    (pass_led),
    .fail_o    (fail_led)
  );

endmodule

// File: rtl/serial_code_lock_checker.sv
module serial_code_lock_checker (
  input logic clk,
  input logic rst,
  input logic btn_one,
  input logic btn_zero,
  input logic pass_led,
  input logic fail_led
);

  // R1: a reset edge leaves both lamps dark
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pass_led && !fail_led));

  // R9: the two lamps are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_led, fail_led}));

  // R8: a lit verdict does not change without reset
  a_r8_verdict_holds: assert property (@(posedge clk) disable iff (rst)
    (pass_led || fail_led) |=> ($stable(pass_led) && $stable(fail_led)));

  // R4: both buttons rising together leaves the lamps unchanged
  a_r4_both_ignored: assert property (@(posedge clk) disable iff (rst)
    ($rose(btn_one) && $rose(btn_zero)) |=> ($stable(pass_led) && $stable(fail_led)));

  // R7: a verdict only appears right after a cycle with a button high
  a_r7_verdict_needs_press: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_led || fail_led) |-> $past(btn_one || btn_zero));

endmodule

bind serial_code_lock serial_code_lock_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .btn_one  (btn_one),
  .btn_zero (btn_zero),
  .pass_led (pass_led),
  .fail_led (fail_led)
);

// File: tb/serial_code_lock_bench.sv
module serial_code_lock_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_one = 1'b0;
  logic btn_zero = 1'b0;
  logic pass_led;
  logic fail_led;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_code_lock u_serial_code_lock (
    .clk      (clk),
    .rst      (rst),
    .btn_one  (btn_one),
    .btn_zero (btn_zero),
    .pass_led (pass_led),
    .fail_led (fail_led)
  );

  // {code entered first-digit-first as bits [4:1], expected pass at bit [0]}
  localparam int NVEC = 8;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1010_1, 5'b0000_0, 5'b1111_0, 5'b1011_0,
    5'b0010_0, 5'b1000_0, 5'b0101_0, 5'b1110_0
  };

  task automatic chk(input string req, input logic ep, input logic ef);
    checks++;
    if (pass_led !== ep || fail_led !== ef) begin
      errors++;
      $display("FAIL %s: pass_led=%0b fail_led=%0b expected pass_led=%0b fail_led=%0b",
               req, pass_led, fail_led, ep, ef);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic press(input logic d);
    @(negedge clk);
    if (d) btn_one = 1'b1; else btn_zero = 1'b1;
    @(negedge clk);
    btn_one = 1'b0;
    btn_zero = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0, 1'b0);
    rst = 1'b0;

    // Table walk: R2, R5, R6, R7
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      chk("R1 lamps clear after reset", 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) press(VEC[v][4-k]);
      chk("R7 no verdict before fourth digit", 1'b0, 1'b0);
      press(VEC[v][1]);
      if (VEC[v][0]) chk("R2 R5 matching code lights pass", 1'b1, 1'b0);
      else           chk("R6 mismatching code lights fail", 1'b0, 1'b1);
    end

    // R8: presses after a pass are ignored, then reset clears it
    do_reset();
    press(1); press(0); press(1); press(0);
    chk("R5 pass before extra presses", 1'b1, 1'b0);
    press(0); press(1); press(1); press(1);
    chk("R8 pass holds through presses", 1'b1, 1'b0);
    do_reset();
    chk("R1 reset clears pass", 1'b0, 1'b0);

    // R8 on a fail verdict
    press(0); press(0); press(0); press(0);
    press(1); press(0); press(1); press(0);
    chk("R8 fail holds through presses", 1'b0, 1'b1);

    // R3: a held button is a single digit
    do_reset();
    @(negedge clk) btn_one = 1'b1;
    repeat (6) @(negedge clk);
    btn_one = 1'b0;
    @(negedge clk);
    press(0); press(1);
    chk("R3 held button not repeated (3 digits so far)", 1'b0, 1'b0);
    press(0);
    chk("R3 held button counted once", 1'b1, 1'b0);

    // R4: simultaneous rise enters nothing
    do_reset();
    @(negedge clk) begin btn_one = 1'b1; btn_zero = 1'b1; end
    @(negedge clk) begin btn_one = 1'b0; btn_zero = 1'b0; end
    @(negedge clk);
    press(1); press(0); press(1);
    chk("R4 both-button press adds no digit", 1'b0, 1'b0);
    press(0);
    chk("R4 code still matches after both-button press", 1'b1, 1'b0);

    // R1: reset mid-entry clears the digit count
    do_reset();
    press(0); press(1);
    do_reset();
    press(1); press(0); press(1);
    chk("R1 count cleared by reset mid-entry", 1'b0, 1'b0);
    press(0);
    chk("R1 fresh entry after mid-entry reset", 1'b1, 1'b0);

    // R10: button held across reset release is not a press
    @(negedge clk) begin rst = 1'b1; btn_one = 1'b1; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    btn_one = 1'b0;
    @(negedge clk);
    press(1); press(0); press(1); press(0);
    chk("R10 held-through-reset button ignored", 1'b1, 1'b0);

    // R7: early wrong digit stays hidden, R9 only one lamp
    do_reset();
    press(0); press(1); press(1);
    chk("R7 early mismatch not revealed", 1'b0, 1'b0);
    press(1);
    chk("R9 only fail lamp lit", 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule